// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a host reach sixteen 8-bit registers. Thirteen of them are writable control registers whose contents leave the block on a flat output bus. The top three are status registers that show live input values to the host. The target answers to a 7-bit device address. The upper six bits of that address are a fixed prefix, and the lowest bit comes from a strap pin, so two copies can share one bus.

A write transaction works like this. The first byte after the address loads an internal register pointer. Every later byte is stored at the pointer, and the pointer then steps forward. A read sets the pointer with a short write and then issues a repeated START with the read bit set. The target sends the pointed register and keeps streaming the following registers for as long as the host acknowledges. The pointer keeps its value across transactions and wraps at the end of the bank.

SCL and SDA pass through two-flop synchronizers. START and STOP are detected on the synchronized lines. The target pulls SDA low through an active-low output enable and never drives it high.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 110000 followed by `addr_sel_i`. On a mismatch it stays silent, does not acknowledge, and ignores the rest of the transaction.
- R2: In a write, the first byte after the address loads the pointer. Each following byte is acknowledged and written to the register at the pointer, and then the pointer increments. Control register k appears on `ctrl_o[8k+7:8k]`.
- R3: A write burst runs until STOP. The pointer advances from 0x0F to 0x00, so a burst that passes the end of the bank continues at register 0.
- R4: A write of the pointer, followed by a repeated START and the address with R/W = 1, returns the pointed register MSB first. Each bit is valid while SCL is high.
- R5: After each byte read, a host ACK (SDA low on the ninth clock) makes the target send the next register. A host NACK makes it release SDA and stay silent until the next START.
- R6: Addresses 0x0D, 0x0E and 0x0F are read-only. A read of them returns bytes 0, 1 and 2 of `stat_i` as they are at that moment. A write to them is acknowledged and changes no register.
- R7: When the pointer is above 0x0F, writes are acknowledged and ignored, and reads return 0x00.
- R8: After reset every control register is 0x00, and the pointer is 0x00, so a read with no pointer write starts at register 0.
- R9: `sda_oe_n` = 0 pulls SDA low, and `sda_oe_n` = 1 releases it. The output enable changes only while SCL is low and is released outside a transfer.
- R10: A START detected in the middle of a byte abandons that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_n | output | 1 | Active-low SDA pull-down enable |
| addr_sel_i | input | 1 | Strap for the device address LSB |
| stat_i | input | 24 | Live status bytes for addresses 0x0D..0x0F, 0x0D in bits 7:0 |
| ctrl_o | output | 104 | Control registers 0x00..0x0C, register k in bits 8k+7:8k |

## Verification
The bench runs the following directed scenarios against the block's own corner cases:

- **Burst past the bank end.** A write burst runs through the read-only addresses and wraps to register 0. A pointer that saturated or stopped would leave register 0 unchanged. A write decode that missed the read-only range would corrupt the status readback.
- **Status bytes change between reads.** A read-back that latched the status inputs instead of passing them through would return stale bytes.
- **Read ended with NACK.** The bench checks that SDA is released after the NACK. A target that kept streaming would hold SDA low.
- **Wrong address and the strap.** One address differs from the target's only in the strap bit, and the bench checks that it gets no acknowledge. The strap is then flipped so the other value answers, which catches an address compare that ignores the strap.
- **Out-of-bank pointer.** The bench expects reads of 0x00 and no register change. An aliased decode would write the low registers instead.
- **START in the middle of a byte.** A START arrives partway through a byte. The byte that follows must be decoded as a fresh address, which catches a bit counter that is not cleared by START.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_HACK
    } rb_state_e;

    typedef struct packed {
        rb_state_e  st;
        logic [3:0] bit_cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rw;
        logic       ptr_done;
        logic       oe_n;
    } rb_ctl_s;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = STAGES + 1;

    logic [W-1:0] scl_d, scl_q, sda_d, sda_q;
    logic scl_now, scl_prev, sda_prev;

    always_comb begin
        scl_d = {scl_q[W-2:0], scl_i};
        sda_d = {sda_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_now   = scl_q[STAGES-1];
    assign scl_prev  = scl_q[STAGES];
    assign sda_s     = sda_q[STAGES-1];
    assign sda_prev  = sda_q[STAGES];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
    parameter int N_REGS = 16,
    parameter int N_RO   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [7:0]                 waddr,
    input  logic [7:0]                 wdata,
    input  logic [7:0]                 raddr,
    output logic [7:0]                 rdata,
    input  logic [N_RO*8-1:0]          stat_i,
    output logic [(N_REGS-N_RO)*8-1:0] ctrl_o
);
    localparam int         N_RW  = N_REGS - N_RO;
    localparam int         AW    = $clog2(N_REGS);
    localparam logic [7:0] NREG8 = 8'(N_REGS);

    logic [7:0] r_d [N_RW];
    logic [7:0] r_q [N_RW];
    logic [7:0] view [N_REGS];

    for (genvar g = 0; g < N_RW; g++) begin : g_rw
        always_comb r_d[g] = (we && waddr == 8'(g)) ? wdata : r_q[g];
        assign ctrl_o[g*8 +: 8] = r_q[g];
        assign view[g] = r_q[g];
    end

    for (genvar g = N_RW; g < N_REGS; g++) begin : g_ro
        assign view[g] = stat_i[(g-N_RW)*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RW; i++) r_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_RW; i++) r_q[i] <= r_d[i];
        end
    end

    assign rdata = (raddr < NREG8) ? view[raddr[AW-1:0]] : 8'h00;

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter int         N_REGS      = 16,
    parameter int         N_RO        = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_PREFIX  = 6'b110000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_n,
    input  logic                       addr_sel_i,
    input  logic [N_RO*8-1:0]          stat_i,
    output logic [(N_REGS-N_RO)*8-1:0] ctrl_o
);
    import i2c_rb_pkg::*;

    localparam logic [7:0] LAST_PTR = 8'(N_REGS - 1);

    rb_ctl_s    c_d, c_q;
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       we, ptr_inc, addr_hit;
    logic [7:0] rdata;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_regs #(.N_REGS(N_REGS), .N_RO(N_RO)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (c_q.ptr),
        .wdata  (c_q.sh),
        .raddr  (c_q.ptr),
        .rdata  (rdata),
        .stat_i (stat_i),
        .ctrl_o (ctrl_o)
    );

    assign addr_hit = (c_q.sh[7:1] == {DEV_PREFIX, addr_sel_i});

    always_comb begin
        c_d     = c_q;
        we      = 1'b0;
        ptr_inc = 1'b0;
        if (start_det) begin
            c_d.st      = ST_ADDR;
            c_d.bit_cnt = '0;
            c_d.oe_n    = 1'b1;
        end else if (stop_det) begin
            c_d.st   = ST_IDLE;
            c_d.oe_n = 1'b1;
        end else begin
            case (c_q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && c_q.bit_cnt != 4'd8) begin
                        c_d.sh      = {c_q.sh[6:0], sda_s};
                        c_d.bit_cnt = c_q.bit_cnt + 4'd1;
                    end
                    if (scl_fall && c_q.bit_cnt == 4'd8) begin
                        if (c_q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                c_d.oe_n = 1'b0;
                                c_d.rw   = c_q.sh[0];
                                c_d.st   = ST_AACK;
                            end else begin
                                c_d.st = ST_IDLE;
                            end
                        end else begin
                            c_d.oe_n = 1'b0;
                            c_d.st   = ST_RACK;
                            if (!c_q.ptr_done) begin
                                c_d.ptr      = c_q.sh;
                                c_d.ptr_done = 1'b1;
                            end else begin
                                we      = 1'b1;
                                ptr_inc = 1'b1;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        c_d.bit_cnt = '0;
                        if (c_q.rw) begin
                            c_d.sh   = rdata;
                            c_d.oe_n = rdata[7];
                            c_d.st   = ST_TX;
                        end else begin
                            c_d.oe_n     = 1'b1;
                            c_d.ptr_done = 1'b0;
                            c_d.st       = ST_RX;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        c_d.oe_n    = 1'b1;
                        c_d.bit_cnt = '0;
                        c_d.st      = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) c_d.bit_cnt = c_q.bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (c_q.bit_cnt == 4'd8) begin
                            c_d.oe_n    = 1'b1;
                            c_d.bit_cnt = '0;
                            c_d.st      = ST_HACK;
                        end else begin
                            c_d.sh   = {c_q.sh[6:0], 1'b0};
                            c_d.oe_n = c_q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            c_d.bit_cnt = 4'd1;
                            ptr_inc     = 1'b1;
                        end else begin
                            c_d.st = ST_IDLE;
                        end
                    end
                    if (scl_fall && c_q.bit_cnt == 4'd1) begin
                        c_d.sh      = rdata;
                        c_d.oe_n    = rdata[7];
                        c_d.bit_cnt = '0;
                        c_d.st      = ST_TX;
                    end
                end
                default: ;
            endcase
        end
        if (ptr_inc) c_d.ptr = (c_q.ptr == LAST_PTR) ? 8'h00 : c_q.ptr + 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, bit_cnt: '0, sh: '0, ptr: '0,
                     rw: 1'b0, ptr_done: 1'b0, oe_n: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_n = c_q.oe_n;

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
    parameter int         N_REGS     = 16,
    parameter int         N_RO       = 3,
    parameter logic [5:0] DEV_PREFIX = 6'b110000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_i,
    input logic                       sda_oe_n,
    input logic                       addr_sel_i,
    input i2c_rb_pkg::rb_state_e      st,
    input logic [6:0]                 sh_hi,
    input logic                       we,
    input logic [7:0]                 waddr,
    input logic                       ptr_inc,
    input logic [7:0]                 ptr,
    input logic [(N_REGS-N_RO)*8-1:0] ctrl_o
);
    import i2c_rb_pkg::*;

    localparam logic [7:0] NRW8 = 8'(N_REGS - N_RO);
    localparam logic [7:0] LAST = 8'(N_REGS - 1);

    // R1: an acknowledged address always matches prefix plus strap
    a_r1_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK) |-> (sh_hi == {DEV_PREFIX, addr_sel_i}));

    // R3: pointer steps from the last register back to zero
    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr == LAST) |=> (ptr == 8'h00));

    // R5: idle target never pulls SDA
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> sda_oe_n);

    // R6: control outputs move only on a write into the writable range
    a_r6_ro_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && waddr < NRW8) |=> $stable(ctrl_o));

    // R8: control registers start at zero
    a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == '0));

    // R9: output enable changes only while SCL is low
    a_r9_sda_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_n != $past(sda_oe_n)) |-> !scl_i);

endmodule

bind i2c_regbank_target i2c_rb_checker #(
    .N_REGS(N_REGS), .N_RO(N_RO), .DEV_PREFIX(DEV_PREFIX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_n   (sda_oe_n),
    .addr_sel_i (addr_sel_i),
    .st         (c_q.st),
    .sh_hi      (c_q.sh[7:1]),
    .we         (we),
    .waddr      (c_q.ptr),
    .ptr_inc    (ptr_inc),
    .ptr        (c_q.ptr),
    .ctrl_o     (ctrl_o)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;
    localparam int         N_REGS = 16;
    localparam int         N_RO   = 3;
    localparam int         N_RW   = N_REGS - N_RO;
    localparam logic [6:0] DEV0   = 7'b1100000;
    localparam logic [6:0] DEV1   = 7'b1100001;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 scl_h = 1'b1;
    logic                 sda_h = 1'b1;
    logic                 addr_sel = 1'b0;
    logic [N_RO*8-1:0]    stat = 24'h0;
    logic [N_RW*8-1:0]    ctrl;
    logic                 sda_oe_n;
    wire                  sda_bus = sda_h & sda_oe_n;
    int                   n_chk = 0;
    int                   n_err = 0;

    always #5 clk = ~clk;

    i2c_regbank_target u_i2c_regbank_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_h),
        .sda_i      (sda_bus),
        .sda_oe_n   (sda_oe_n),
        .addr_sel_i (addr_sel),
        .stat_i     (stat),
        .ctrl_o     (ctrl)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] creg(input int k);
        return ctrl[k*8 +: 8];
    endfunction

    task automatic hq();
        repeat (20) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; hq();
        sda_h = 1'b0; hq();
        scl_h = 1'b0; hq();
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b0; hq();
        scl_h = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; hq();
            scl_h = 1'b1; hq();
            scl_h = 1'b0; hq();
        end
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        ack = sda_bus;
        scl_h = 1'b0; hq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq(); scl_h = 1'b1; hq();
            d[i] = sda_bus;
            scl_h = 1'b0;
        end
        hq(); sda_h = nack; hq();
        scl_h = 1'b1; hq();
        scl_h = 1'b0; hq();
        sda_h = 1'b1;
    endtask

    task automatic wr_burst(input logic [6:0] dev, input logic [7:0] p,
                            input logic [7:0] d [6], input int n, input string req);
        logic ack;
        bus_start();
        send_byte({dev, 1'b0}, ack); check({req, " addr ack"}, ack, 1'b0);
        send_byte(p, ack);           check({req, " ptr ack"}, ack, 1'b0);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);    check({req, " data ack"}, ack, 1'b0);
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] p, input int n, output logic [7:0] d [6]);
        logic ack;
        bus_start();
        send_byte({DEV0, 1'b0}, ack); check("R4 ptr-write addr ack", ack, 1'b0);
        send_byte(p, ack);            check("R4 ptr ack", ack, 1'b0);
        bus_rstart();
        send_byte({DEV0, 1'b1}, ack); check("R4 read addr ack", ack, 1'b0);
        for (int i = 0; i < n; i++) recv_byte(i == n - 1, d[i]);
        hq();
        check("R5 SDA released after NACK", sda_oe_n, 1'b1);
        bus_stop();
    endtask

    task automatic t_reset();
        for (int k = 0; k < N_RW; k++) check("R8 control reg reset", creg(k), 8'h00);
        check("R9 SDA released in reset", sda_oe_n, 1'b1);
    endtask

    task automatic t_read_after_reset();
        logic ack;
        logic [7:0] b0, b1;
        bus_start();
        send_byte({DEV0, 1'b1}, ack); check("R8 read addr ack", ack, 1'b0);
        recv_byte(1'b0, b0);
        recv_byte(1'b1, b1);
        bus_stop();
        check("R8 reset pointer reads reg0", b0, 8'h00);
        check("R8 next reg after reset", b1, 8'h00);
    endtask

    task automatic t_write_burst();
        wr_burst(DEV0, 8'h02, '{8'hA5, 8'h3C, 8'h77, 8'h00, 8'h00, 8'h00}, 3, "R2");
        check("R2 reg2", creg(2), 8'hA5);
        check("R2 reg3", creg(3), 8'h3C);
        check("R2 reg4", creg(4), 8'h77);
    endtask

    task automatic t_read_repeated();
        logic [7:0] d [6];
        rd_burst(8'h02, 3, d);
        check("R4 first byte", d[0], 8'hA5);
        check("R5 ACK advances", d[1], 8'h3C);
        check("R5 ACK advances again", d[2], 8'h77);
    endtask

    task automatic t_addr_match();
        logic ack;
        logic [N_RW*8-1:0] snap;
        snap = ctrl;
        bus_start();
        send_byte({DEV1, 1'b0}, ack); check("R1 strap mismatch NACK", ack, 1'b1);
        send_byte(8'h06, ack);        check("R1 ignored byte not acked", ack, 1'b1);
        bus_stop();
        check("R1 mismatch leaves regs", ctrl, snap);
        addr_sel = 1'b1;
        bus_start();
        send_byte({DEV0, 1'b0}, ack); check("R1 old address now NACK", ack, 1'b1);
        bus_stop();
        wr_burst(DEV1, 8'h06, '{8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1, "R1");
        check("R1 strapped write lands", creg(6), 8'h5A);
        addr_sel = 1'b0;
    endtask

    task automatic t_wrap_ro();
        logic [7:0] d [6];
        stat = 24'h2B1A09;
        wr_burst(DEV0, 8'h0C, '{8'h11, 8'hE1, 8'hE2, 8'hE3, 8'h99, 8'h00}, 5, "R3");
        check("R3 reg12 before wrap", creg(12), 8'h11);
        check("R3 wrap to reg0", creg(0), 8'h99);
        check("R6 other reg untouched", creg(2), 8'hA5);
        rd_burst(8'h0D, 3, d);
        check("R6 RO 0x0D unchanged by write", d[0], 8'h09);
        check("R6 RO 0x0E unchanged by write", d[1], 8'h1A);
        check("R6 RO 0x0F unchanged by write", d[2], 8'h2B);
    endtask

    task automatic t_status_live();
        logic [7:0] d [6];
        stat = 24'hC3814E;
        rd_burst(8'h0D, 4, d);
        check("R6 status byte0", d[0], 8'h4E);
        check("R6 status byte1", d[1], 8'h81);
        check("R6 status byte2", d[2], 8'hC3);
        check("R3 read wraps to reg0", d[3], 8'h99);
        stat = 24'h5566D0;
        rd_burst(8'h0E, 1, d);
        check("R6 status live update", d[0], 8'h66);
    endtask

    task automatic t_outside();
        logic [7:0] d [6];
        logic [N_RW*8-1:0] snap;
        snap = ctrl;
        wr_burst(DEV0, 8'h20, '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}, 2, "R7");
        check("R7 out-of-bank write ignored", ctrl, snap);
        rd_burst(8'h20, 2, d);
        check("R7 out-of-bank read zero", d[0], 8'h00);
        check("R7 out-of-bank read zero next", d[1], 8'h00);
    endtask

    task automatic t_restart_mid();
        logic ack;
        bus_start();
        for (int i = 0; i < 4; i++) begin
            sda_h = (i < 2); hq();
            scl_h = 1'b1; hq();
            scl_h = 1'b0; hq();
        end
        bus_rstart();
        send_byte({DEV0, 1'b0}, ack); check("R10 addr after mid-byte START", ack, 1'b0);
        send_byte(8'h05, ack);        check("R10 ptr ack", ack, 1'b0);
        send_byte(8'h42, ack);        check("R10 data ack", ack, 1'b0);
        bus_stop();
        check("R10 write after restart", creg(5), 8'h42);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        hq();
        fork
            begin
                t_read_after_reset();
                t_write_burst();
                t_read_repeated();
                t_addr_match();
                t_wrap_ro();
                t_status_live();
                t_outside();
                t_restart_mid();
            end
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog R1..: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule